// File: doc/BRIEF.md
# Flash Command Buffer Controller

This block sits between a simple single-beat processor bus and the sequencer that drives a flash array. Bus accesses with the top address bit clear fall into the flash window; those with it set reach four control registers. Software stages an operation by writing one 32-bit word to the target location in the flash window, then writing an operation code to the command register, then writing a launch bit to the status register. A launched operation enters a holding stage and moves to an active stage as soon as the active stage is free. This lets a second operation wait behind one that is running.

The active operation is presented to the array sequencer as an opcode, address and data with a busy level. Its length is counted in ticks of a timebase. The timebase is divided down from the bus clock by a programmable divider register. Program and erase operations need the high-voltage supply. When the supply was off at the start, extra setup ticks are added. When a program completes and the queued operation is a program to the same row, the supply is left on so that the next operation skips the setup ticks. Two flags, buffer-empty and operation-done, can each drive an interrupt line.

Top module: `flash_cmd_buffer`

## Requirements
- R1: Each cycle with `busReq` high is answered by `busAck` high in the next cycle. A read of the flash window returns the `arrayRdata` value sampled with the request and does not raise `busErr`.
- R2: A flash-window write whose `busSize` is not word (encoding 0 = byte, 1 = half-word, 2 = word) is answered with `busErr` high, and it leaves the staged operation and the flags untouched.
- R3: When `busAddr[15]` = 1, the access goes to a register selected by `busAddr[3:2]`: 0 = timebase divider (bits 5:0), 1 = interrupt enables (bit 0 buffer-empty, bit 1 done), 2 = status, 3 = command (bits 7:0). Status reads as bit 0 buffer-empty, bit 1 done, bit 2 sequence error.
- R4: An operation is staged only by this order: a flash word write, then a command write, then a status write with bit 0 set. Any access that breaks the order sets the sequence-error flag and discards what was staged.
- R5: A launch before the divider register has ever been written is refused and sets the sequence-error flag.
- R6: A launch while the holding stage is occupied is refused and sets the sequence-error flag.
- R7: An operation in the holding stage moves to the active stage on the first clock edge at which the active stage is empty. The buffer-empty flag is 0 while the holding stage is occupied and returns to 1 when the operation moves.
- R8: After a divider write of value D, one timebase tick occurs every D+1 clocks. The valid codes are 0x20 program (3 ticks), 0x40 erase (5 ticks) and 0x05 verify (2 ticks). A command write with any other code is a sequence error.
- R9: `hvOn` rises when a program or erase becomes active. Two setup ticks are added if `hvOn` was low at that moment. At completion `hvOn` stays high only if the finishing operation is a program and the holding stage has a program whose address bits 14:6 match. Otherwise it falls.
- R10: The done flag is set when the active operation completes while the holding stage is empty. Writing 1 to status bit 1 clears the done flag, and writing 1 to bit 2 clears the sequence-error flag. A set event in the same cycle wins over the clear.
- R11: `irqBufEmpty` equals buffer-empty AND enable bit 0. `irqDone` equals done AND enable bit 1.
- R12: After reset no operation is active, `hvOn` is low, the flags read buffer-empty only, and the enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busReq | input | 1 | Transfer request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | 0 byte, 1 half-word, 2 word |
| busAddr | input | 16 | Byte address; bit 15 selects registers |
| busWdata | input | 32 | Write data |
| arrayRdata | input | 32 | Array read data for flash-window reads |
| busAck | output | 1 | Response strobe, one cycle after request |
| busErr | output | 1 | Transfer error with the response |
| busRdata | output | 32 | Read data with the response |
| seqActive | output | 1 | An operation is executing |
| seqCmd | output | 8 | Opcode of the executing operation |
| seqAddr | output | 16 | Address of the executing operation |
| seqData | output | 32 | Data of the executing operation |
| hvOn | output | 1 | High-voltage supply request |
| irqBufEmpty | output | 1 | Buffer-empty interrupt |
| irqDone | output | 1 | Operation-done interrupt |

## Verification
The assertions assume that a bus request is held for exactly one cycle and that its inputs are stable for that cycle. They also assume that every divider value and tick count is at least one tick, so an active operation always ends on a tick. The stimulus drives each access for one clock and then drops the request. It then moves through the legal order, each way of breaking it, narrow writes, and back-to-back launches to the same row and to different rows. A behavioural model kept in queues predicts every output on every cycle.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam logic [7:0] OP_PROG   = 8'h20;
  localparam logic [7:0] OP_ERASE  = 8'h40;
  localparam logic [7:0] OP_VERIFY = 8'h05;

  typedef enum logic [1:0] {
    REG_DIV  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_CMD  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_DATA = 2'd1,
    SEQ_CMD  = 2'd2
  } seqState_e;

  typedef struct packed {
    logic capData;
    logic capCmd;
    logic launch;
    logic wrDiv;
  } dpStrobe_t;

  function automatic logic opValid(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE) || (op == OP_VERIFY);
  endfunction

  function automatic logic opNeedsHv(input logic [7:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction
endpackage

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import fcb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReq,
  input  logic             busWrite,
  input  logic [1:0]       busSize,
  input  logic [AW-1:0]    busAddr,
  input  logic [31:0]      busWdata,
  input  logic [31:0]      arrayRdata,
  input  logic             holdValid,
  input  logic             doneEvt,
  input  logic             divSet,
  input  logic [DIV_W-1:0] divVal,
  input  logic [7:0]       stagedOp,
  output dpStrobe_t        strobe,
  output logic             busAck,
  output logic             busErr,
  output logic [31:0]      busRdata,
  output logic             irqBufEmpty,
  output logic             irqDone
);
  localparam logic [1:0] SIZE_WORD = 2'd2;

  seqState_e seqState, seqNext;
  regSel_e   regSel;
  logic      isFlash, flashWr, regWr, wordOk, seqErr, statWr;
  logic      cmdDone, accErr;
  logic [1:0] irqEn;
  logic [31:0] readMux;
  logic      unusedBits;

  assign isFlash = !busAddr[AW-1];
  assign regSel  = regSel_e'(busAddr[3:2]);
  assign wordOk  = (busSize == SIZE_WORD);
  assign flashWr = busReq && busWrite && isFlash;
  assign regWr   = busReq && busWrite && !isFlash;
  assign statWr  = regWr && (regSel == REG_STAT);
  assign unusedBits = ^{busWdata[31:8], busAddr[AW-2:4], busAddr[1:0]};

  always_comb begin
    strobe  = '0;
    seqErr  = 1'b0;
    seqNext = seqState;
    if (flashWr && wordOk) begin
      if (seqState == SEQ_IDLE) begin
        strobe.capData = 1'b1;
        seqNext = SEQ_DATA;
      end else begin
        seqErr  = 1'b1;
        seqNext = SEQ_IDLE;
      end
    end
    if (regWr && regSel == REG_CMD) begin
      if (seqState == SEQ_DATA && opValid(busWdata[7:0])) begin
        strobe.capCmd = 1'b1;
        seqNext = SEQ_CMD;
      end else begin
        seqErr  = 1'b1;
        seqNext = SEQ_IDLE;
      end
    end
    if (statWr && busWdata[0]) begin
      if (seqState == SEQ_CMD && divSet && !holdValid) strobe.launch = 1'b1;
      else seqErr = 1'b1;
      seqNext = SEQ_IDLE;
    end
    if (regWr && regSel == REG_DIV) strobe.wrDiv = 1'b1;
  end

  always_comb begin
    readMux = '0;
    if (isFlash) readMux = arrayRdata;
    else begin
      case (regSel)
        REG_DIV:  readMux = {{(32-DIV_W){1'b0}}, divVal};
        REG_CTRL: readMux = {30'b0, irqEn};
        REG_STAT: readMux = {29'b0, accErr, cmdDone, !holdValid};
        default:  readMux = {24'b0, stagedOp};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SEQ_IDLE;
      cmdDone  <= 1'b0;
      accErr   <= 1'b0;
      irqEn    <= '0;
      busAck   <= 1'b0;
      busErr   <= 1'b0;
      busRdata <= '0;
    end else begin
      seqState <= seqNext;
      if (doneEvt && !holdValid) cmdDone <= 1'b1;
      else if (statWr && busWdata[1]) cmdDone <= 1'b0;
      if (seqErr) accErr <= 1'b1;
      else if (statWr && busWdata[2]) accErr <= 1'b0;
      if (regWr && regSel == REG_CTRL) irqEn <= busWdata[1:0];
      busAck   <= busReq;
      busErr   <= flashWr && !wordOk;
      busRdata <= (busReq && !busWrite) ? readMux : '0;
    end
  end

  assign irqBufEmpty = irqEn[0] && !holdValid;
  assign irqDone     = irqEn[1] && cmdDone;

  assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busReq));

  assert_narrow_write_err_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && !busAddr[AW-1] && busSize != SIZE_WORD) |=> (busAck && busErr));

  assert_order_break_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && !busAddr[AW-1] && busSize == SIZE_WORD && seqState != SEQ_IDLE)
      |=> accErr);
endmodule

// File: rtl/fcb_datapath.sv
module fcb_datapath
  import fcb_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DIV_W        = 6,
  parameter int CNT_W        = 8,
  parameter int PROG_TICKS   = 3,
  parameter int ERASE_TICKS  = 5,
  parameter int VERIFY_TICKS = 2,
  parameter int SETUP_TICKS  = 2,
  parameter int ROW_LSB      = 6,
  parameter int ROW_MSB      = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [31:0]      wdata,
  input  logic [AW-1:0]    addr,
  output logic             holdValid,
  output logic             activeValid,
  output logic             doneEvt,
  output logic             divSet,
  output logic [DIV_W-1:0] divVal,
  output logic [7:0]       stagedOp,
  output logic [7:0]       seqCmd,
  output logic [AW-1:0]    seqAddr,
  output logic [31:0]      seqData,
  output logic             hvOn
);
  localparam int ROW_W = ROW_MSB - ROW_LSB + 1;

  logic [DIV_W-1:0] divCnt;
  logic             tick, moveEvt, keepHv;
  logic [AW-1:0]    stAddr, hAddr;
  logic [31:0]      stData, hData;
  logic [7:0]       hOp;
  logic [CNT_W-1:0] remain, loadTicks;
  logic [ROW_W-1:0] hRow, aRow;

  assign tick = divSet && (divCnt == divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSet <= 1'b0;
      divVal <= '0;
      divCnt <= '0;
    end else if (strobe.wrDiv) begin
      divSet <= 1'b1;
      divVal <= wdata[DIV_W-1:0];
      divCnt <= '0;
    end else if (divSet) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stAddr   <= '0;
      stData   <= '0;
      stagedOp <= '0;
    end else begin
      if (strobe.capData) begin
        stAddr <= addr;
        stData <= wdata;
      end
      if (strobe.capCmd) stagedOp <= wdata[7:0];
    end
  end

  always_comb begin
    int t;
    case (hOp)
      OP_PROG:  t = PROG_TICKS;
      OP_ERASE: t = ERASE_TICKS;
      default:  t = VERIFY_TICKS;
    endcase
    if (opNeedsHv(hOp) && !hvOn) t = t + SETUP_TICKS;
    loadTicks = CNT_W'(t);
  end

  assign hRow    = hAddr[ROW_MSB:ROW_LSB];
  assign aRow    = seqAddr[ROW_MSB:ROW_LSB];
  assign moveEvt = holdValid && !activeValid;
  assign doneEvt = activeValid && tick && (remain == CNT_W'(1));
  assign keepHv  = (seqCmd == OP_PROG) && holdValid && (hOp == OP_PROG) && (hRow == aRow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid   <= 1'b0;
      hAddr       <= '0;
      hData       <= '0;
      hOp         <= '0;
      activeValid <= 1'b0;
      seqCmd      <= '0;
      seqAddr     <= '0;
      seqData     <= '0;
      remain      <= '0;
      hvOn        <= 1'b0;
    end else begin
      if (strobe.launch) begin
        holdValid <= 1'b1;
        hAddr     <= stAddr;
        hData     <= stData;
        hOp       <= stagedOp;
      end else if (moveEvt) begin
        holdValid <= 1'b0;
      end
      if (moveEvt) begin
        activeValid <= 1'b1;
        seqCmd      <= hOp;
        seqAddr     <= hAddr;
        seqData     <= hData;
        remain      <= loadTicks;
        if (opNeedsHv(hOp)) hvOn <= 1'b1;
      end else if (doneEvt) begin
        activeValid <= 1'b0;
        hvOn        <= keepHv;
      end else if (activeValid && tick) begin
        remain <= remain - 1'b1;
      end
    end
  end

  assert_hold_after_div_R5: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |-> divSet);

  assert_hold_moves_R7: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && !activeValid) |=> (activeValid && !holdValid));

  assert_hv_needs_work_R9: assert property (@(posedge clk) disable iff (!rstN)
    hvOn |-> (activeValid || holdValid));
endmodule

// File: rtl/flash_cmd_buffer.sv
module flash_cmd_buffer
  import fcb_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DIV_W        = 6,
  parameter int CNT_W        = 8,
  parameter int PROG_TICKS   = 3,
  parameter int ERASE_TICKS  = 5,
  parameter int VERIFY_TICKS = 2,
  parameter int SETUP_TICKS  = 2,
  parameter int ROW_LSB      = 6,
  parameter int ROW_MSB      = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busReq,
  input  logic          busWrite,
  input  logic [1:0]    busSize,
  input  logic [AW-1:0] busAddr,
  input  logic [31:0]   busWdata,
  input  logic [31:0]   arrayRdata,
  output logic          busAck,
  output logic          busErr,
  output logic [31:0]   busRdata,
  output logic          seqActive,
  output logic [7:0]    seqCmd,
  output logic [AW-1:0] seqAddr,
  output logic [31:0]   seqData,
  output logic          hvOn,
  output logic          irqBufEmpty,
  output logic          irqDone
);
  dpStrobe_t        strobe;
  logic             holdValid, doneEvt, divSet;
  logic [DIV_W-1:0] divVal;
  logic [7:0]       stagedOp;

  fcb_ctrl #(.AW(AW), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .arrayRdata(arrayRdata),
    .holdValid(holdValid), .doneEvt(doneEvt), .divSet(divSet), .divVal(divVal),
    .stagedOp(stagedOp), .strobe(strobe), .busAck(busAck), .busErr(busErr),
    .busRdata(busRdata), .irqBufEmpty(irqBufEmpty), .irqDone(irqDone)
  );

  fcb_datapath #(
    .AW(AW), .DIV_W(DIV_W), .CNT_W(CNT_W), .PROG_TICKS(PROG_TICKS),
    .ERASE_TICKS(ERASE_TICKS), .VERIFY_TICKS(VERIFY_TICKS), .SETUP_TICKS(SETUP_TICKS),
    .ROW_LSB(ROW_LSB), .ROW_MSB(ROW_MSB)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata), .addr(busAddr),
    .holdValid(holdValid), .activeValid(seqActive), .doneEvt(doneEvt), .divSet(divSet),
    .divVal(divVal), .stagedOp(stagedOp), .seqCmd(seqCmd), .seqAddr(seqAddr),
    .seqData(seqData), .hvOn(hvOn)
  );
endmodule

// File: tb/flash_cmd_buffer_bench.sv
module flash_cmd_buffer_bench;
  localparam int SETUP = 2;
  localparam logic [15:0] A_DIV = 16'h8000, A_CTRL = 16'h8004, A_STAT = 16'h8008, A_CMD = 16'h800C;

  logic clk = 1'b0, rstN = 1'b0;
  logic busReq = 1'b0, busWrite = 1'b0;
  logic [1:0] busSize = 2'd0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0, arrayRdata = '0;
  logic busAck, busErr, seqActive, hvOn, irqBufEmpty, irqDone;
  logic [31:0] busRdata, seqData;
  logic [7:0] seqCmd;
  logic [15:0] seqAddr;

  always #4 clk = ~clk;

  flash_cmd_buffer u_flash_cmd_buffer (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .arrayRdata(arrayRdata), .busAck(busAck),
    .busErr(busErr), .busRdata(busRdata), .seqActive(seqActive), .seqCmd(seqCmd),
    .seqAddr(seqAddr), .seqData(seqData), .hvOn(hvOn), .irqBufEmpty(irqBufEmpty),
    .irqDone(irqDone)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0;
  string curTag = "R1", eTag = "R1";

  // reference model state
  int mSeq, aRem, divV, cnt;
  bit [15:0] sAddr, aA;
  bit [31:0] sData, aD;
  bit [7:0] sOp, aO;
  bit [15:0] qA[$];
  bit [31:0] qD[$];
  bit [7:0] qO[$];
  bit aV, hv, divS, done, accF, eAck, eErr;
  bit [1:0] en;
  bit [31:0] eRd;

  function automatic int baseTicks(bit [7:0] op);
    if (op == 8'h20) return 3;
    if (op == 8'h40) return 5;
    return 2;
  endfunction

  function automatic bit needHv(bit [7:0] op);
    return op == 8'h20 || op == 8'h40;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin : model
    bit tick, hOld, isFl, wr, fin, err, launch, statW;
    int sel;
    if (!rstN) begin
      mSeq = 0; aRem = 0; divV = 0; cnt = 0; sAddr = 0; sData = 0; sOp = 0;
      aA = 0; aD = 0; aO = 0; aV = 0; hv = 0; divS = 0; done = 0; accF = 0;
      en = 0; eAck = 0; eErr = 0; eRd = 0;
      qA.delete(); qD.delete(); qO.delete();
    end else begin
      tick = divS && cnt == divV;
      hOld = qO.size() != 0;
      isFl = !busAddr[15];
      sel = int'(busAddr[3:2]);
      wr = busReq && busWrite;
      statW = wr && !isFl && sel == 2;
      eAck = busReq;
      eErr = wr && isFl && busSize != 2'd2;
      eTag = curTag;
      eRd = 0;
      if (busReq && !busWrite) begin
        if (isFl) eRd = arrayRdata;
        else if (sel == 0) eRd = 32'(divV);
        else if (sel == 1) eRd = {30'b0, en};
        else if (sel == 2) eRd = {29'b0, accF, done, !hOld};
        else eRd = {24'b0, sOp};
      end
      err = 0; launch = 0;
      if (wr && isFl && busSize == 2'd2) begin
        if (mSeq == 0) begin sAddr = busAddr; sData = busWdata; mSeq = 1; end
        else begin err = 1; mSeq = 0; end
      end
      if (wr && !isFl && sel == 3) begin
        if (mSeq == 1 && (busWdata[7:0] == 8'h20 || busWdata[7:0] == 8'h40 || busWdata[7:0] == 8'h05)) begin
          sOp = busWdata[7:0]; mSeq = 2;
        end else begin err = 1; mSeq = 0; end
      end
      if (statW && busWdata[0]) begin
        if (mSeq == 2 && divS && !hOld) launch = 1; else err = 1;
        mSeq = 0;
      end
      if (wr && !isFl && sel == 1) en = busWdata[1:0];
      fin = aV && tick && aRem == 1;
      if (!aV && hOld) begin
        aV = 1; aA = qA.pop_front(); aD = qD.pop_front(); aO = qO.pop_front();
        aRem = baseTicks(aO) + ((needHv(aO) && !hv) ? SETUP : 0);
        if (needHv(aO)) hv = 1;
      end else if (fin) begin
        hv = aO == 8'h20 && hOld && qO[0] == 8'h20 && qA[0][14:6] == aA[14:6];
        aV = 0;
      end else if (aV && tick) aRem--;
      if (launch) begin qA.push_back(sAddr); qD.push_back(sData); qO.push_back(sOp); end
      if (fin && !hOld) done = 1; else if (statW && busWdata[1]) done = 0;
      if (err) accF = 1; else if (statW && busWdata[2]) accF = 0;
      if (wr && !isFl && sel == 0) begin divS = 1; divV = int'(busWdata[5:0]); cnt = 0; end
      else if (divS) cnt = tick ? 0 : cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin
      chk("R1 ack", {31'b0, busAck}, {31'b0, eAck});
      chk("R2 err", {31'b0, busErr}, {31'b0, eErr});
      if (busAck) chk({eTag, " rdata"}, busRdata, eRd);
      chk("R7 active", {31'b0, seqActive}, {31'b0, aV});
      if (aV) begin
        chk("R7 cmd", {24'b0, seqCmd}, {24'b0, aO});
        chk("R7 addr", {16'b0, seqAddr}, {16'b0, aA});
        chk("R7 data", seqData, aD);
      end
      chk("R9 hv", {31'b0, hvOn}, {31'b0, hv});
      chk("R11 irqBufEmpty", {31'b0, irqBufEmpty}, {31'b0, en[0] && qO.size() == 0});
      chk("R11 irqDone", {31'b0, irqDone}, {31'b0, en[1] && done});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic access(bit w, bit [1:0] sz, bit [15:0] a, bit [31:0] d, string tag);
    @(negedge clk);
    busReq = 1; busWrite = w; busSize = sz; busAddr = a; busWdata = d;
    arrayRdata = {a, ~a}; curTag = tag;
    @(negedge clk);
    busReq = 0; busWrite = 0;
  endtask

  task automatic issue(bit [15:0] a, bit [31:0] d, bit [7:0] op, string tag);
    access(1, 2, a, d, tag);
    access(1, 2, A_CMD, {24'b0, op}, tag);
    access(1, 2, A_STAT, 32'h1, tag);
  endtask

  task automatic drain();
    while (aV || qO.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    running = 1;
    // R12: reset state at the ports
    chk("R12 active", {31'b0, seqActive}, 32'd0);
    chk("R12 hv", {31'b0, hvOn}, 32'd0);
    chk("R12 irq", {30'b0, irqBufEmpty, irqDone}, 32'd0);
    access(0, 2, A_STAT, 0, "R12");
    access(0, 2, A_CTRL, 0, "R12");
    // R5: launch before divider write is refused
    issue(16'h0040, 32'h1111_0000, 8'h20, "R5");
    access(0, 2, A_STAT, 0, "R5");
    access(1, 2, A_STAT, 32'h4, "R10");
    // R3, R8: divider and enables
    access(1, 2, A_DIV, 32'd2, "R8");
    access(0, 2, A_DIV, 0, "R3");
    access(1, 2, A_CTRL, 32'h3, "R11");
    access(0, 2, A_CTRL, 0, "R3");
    // R1: flash reads
    access(0, 2, 16'h0123, 0, "R1");
    access(0, 0, 16'h7FFC, 0, "R1");
    // R2: narrow writes mid-sequence leave it intact
    access(1, 2, 16'h0080, 32'hCAFE_0001, "R2");
    access(1, 0, 16'h0081, 32'h0, "R2");
    access(1, 1, 16'h0082, 32'h0, "R2");
    access(1, 2, A_CMD, 32'h20, "R2");
    access(1, 2, A_STAT, 32'h1, "R2");
    access(0, 2, A_STAT, 0, "R2");
    drain();
    access(0, 2, A_STAT, 0, "R10");
    access(1, 2, A_STAT, 32'h2, "R10");
    access(0, 2, A_STAT, 0, "R10");
    // R4: order violations
    access(1, 2, A_CMD, 32'h20, "R4");
    access(0, 2, A_STAT, 0, "R4");
    access(1, 2, A_STAT, 32'h4, "R4");
    access(1, 2, 16'h0100, 32'h5, "R4");
    access(1, 2, 16'h0104, 32'h6, "R4");
    access(0, 2, A_STAT, 0, "R4");
    access(1, 2, A_STAT, 32'h4, "R4");
    access(1, 2, 16'h0100, 32'h5, "R8");
    access(1, 2, A_CMD, 32'h33, "R8");
    access(0, 2, A_STAT, 0, "R8");
    access(1, 2, A_STAT, 32'h5, "R4");
    access(0, 2, A_STAT, 0, "R4");
    access(1, 2, A_STAT, 32'h4, "R4");
    // R9: same-row programs keep supply on
    issue(16'h0040, 32'hAAAA_0001, 8'h20, "R9");
    issue(16'h0044, 32'hAAAA_0002, 8'h20, "R7");
    access(0, 2, A_STAT, 0, "R7");
    drain();
    // R9: different rows drop supply
    issue(16'h0040, 32'hBBBB_0001, 8'h20, "R9");
    issue(16'h0080, 32'hBBBB_0002, 8'h20, "R9");
    drain();
    // R6: third launch while holding stage full
    issue(16'h0100, 32'hCCCC_0001, 8'h40, "R6");
    issue(16'h0200, 32'hCCCC_0002, 8'h20, "R6");
    issue(16'h0300, 32'hCCCC_0003, 8'h05, "R6");
    access(0, 2, A_STAT, 0, "R6");
    drain();
    access(1, 2, A_STAT, 32'h6, "R10");
    access(0, 2, A_STAT, 0, "R10");
    // R8: fastest timebase, verify then erase
    access(1, 2, A_DIV, 32'd0, "R8");
    issue(16'h0400, 32'hDDDD_0001, 8'h05, "R8");
    issue(16'h0440, 32'hDDDD_0002, 8'h40, "R8");
    drain();
    access(0, 2, A_CMD, 0, "R3");
    access(1, 2, A_CTRL, 32'h1, "R11");
    access(0, 2, A_STAT, 0, "R10");
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule